// File: doc/BRIEF.md
# Removable Storage Card Host Bus Front End

This block is the card-side front end of a removable storage card bus. After reset it settles into one of three personalities: a memory-mapped mode, an I/O-mapped mode, or a disk-controller-compatible mode. The choice comes from the output-enable pin and a strap input, both sampled at the end of a fixed power-up sequence. Once the mode is fixed, the block turns the asynchronous host strobes (output enable, I/O read, I/O write), together with the register-select, card-select and address lines, into reads and writes of a small internal register file.

The outputs to the host are a registered read-data bus, an active-low input-acknowledge that enables the host's input buffers, a ready line, and an interrupt line whose polarity depends on the mode. A stub back end supplies a busy level and an interrupt-request level. The register file has two spaces. The common space holds writable data registers and a read-only status register in its top slot. The attribute space holds configuration bytes computed from their index.

Top module: `card_bus_front`

## Requirements
- R1: `ready` is low while `rst_n` is low and for `RST_CYCLES` clocks after its release. It rises once the sequence has finished and the back end is not busy.
- R2: At the end of the power-up sequence, `mode_out` takes one of three codes. It is 2 (disk-compatible) if `host_oe_n` is low. Otherwise it is 1 (I/O) if `io_strap` is high, and 0 (memory) if not. The mode holds until the next reset.
- R3: In memory mode, a falling output enable with card select low reads the common space when `host_reg_n` is high and the attribute space when it is low. Attribute byte i reads as `ATTR_BASE | i` (0xC0 | i by default).
- R4: In I/O mode, output enable reads only the attribute space, and only with `host_reg_n` low. A cycle with `host_reg_n` high leaves `host_rdata` unchanged. In disk-compatible mode, output enable has no effect.
- R5: An I/O read or I/O write takes effect only while `host_reg_n` and `host_cs_n` are both low. Otherwise `host_rdata` and the register contents are unchanged.
- R6: An I/O write stores the `host_wdata` value present at the rising (trailing) edge of `host_iowr_n`. The value present during the low phase is not stored.
- R7: `ack_n` is low only in I/O mode, while an accepted I/O read at a valid address (below `NREG`) is in progress. A read at an invalid address returns 0 on `host_rdata` and leaves `ack_n` high.
- R8: After the power-up sequence, `ready` follows the inverse of `be_busy` with one clock of delay.
- R9: `irq_out` is active low in memory and I/O modes and active high in disk-compatible mode.
- R10: A rising `be_irq` sets a pending flag that holds the interrupt asserted. Reading the status register clears it: common index `NREG-1`, bit 0 = pending, bit 1 = busy, writes ignored. A new request in the same cycle as a clear wins.
- R11: In disk-compatible mode, I/O reads and writes behave as in I/O mode. In memory mode, I/O read and write strobes are ignored.
- R12: Host strobes that arrive during the power-up sequence have no effect on the register file.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Card clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_cs_n | input | 1 | Card select, active low |
| host_reg_n | input | 1 | Register/attribute select, active low |
| host_oe_n | input | 1 | Output enable strobe; mode strap at reset |
| host_iord_n | input | 1 | I/O read strobe, active low |
| host_iowr_n | input | 1 | I/O write strobe, active low |
| host_addr | input | AW | Host address |
| host_wdata | input | DW | Host write data |
| io_strap | input | 1 | Selects I/O mode over memory mode when not disk-compatible |
| be_busy | input | 1 | Back end busy level |
| be_irq | input | 1 | Back end interrupt request level |
| host_rdata | output | DW | Registered read data |
| ack_n | output | 1 | Input-acknowledge, active low |
| ready | output | 1 | Ready to accept an operation |
| irq_out | output | 1 | Interrupt request, polarity per mode |
| mode_out | output | 2 | Latched mode code |

## Verification
A wrong latched mode shows up on `mode_out` right after the power-up sequence. It also flips `irq_out` polarity on the next clock after an interrupt request. A stale pending flag keeps `irq_out` asserted after a status read and shows up again in bit 0 of the next status read. A strobe accepted in the wrong mode or register-select state shows as a changed `host_rdata` about three clocks after the strobe edge, or as a changed register on the next read-back.

// File: rtl/card_bus_pkg.sv
package card_bus_pkg;
  typedef enum logic [1:0] {
    MODE_MEM = 2'd0,
    MODE_IO  = 2'd1,
    MODE_IDE = 2'd2
  } bus_mode_e;
endpackage

// File: rtl/cbf_sync.sv
// Two-flop synchronizer for a vector of asynchronous levels.
module cbf_sync #(
  parameter int          W       = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_async;
      sync_q <= meta_q;
    end
  end

  assign q_sync = sync_q;
endmodule

// File: rtl/cbf_reset_seq.sv
// Power-up sequence counter and mode latch.
module cbf_reset_seq
  import card_bus_pkg::*;
#(
  parameter int RST_CYCLES = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      oe_s,
  input  logic      strap_s,
  output logic      seq_done,
  output bus_mode_e mode
);
  localparam int CW = $clog2(RST_CYCLES + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d;
  bus_mode_e     mode_q, mode_d;
  logic          last_cyc;

  assign last_cyc = !done_q && (cnt_q == CW'(RST_CYCLES - 1));

  always_comb begin
    cnt_d  = cnt_q;
    done_d = done_q;
    mode_d = mode_q;
    if (!done_q) begin
      cnt_d = cnt_q + CW'(1);
    end
    if (last_cyc) begin
      done_d = 1'b1;
      if (!oe_s)        mode_d = MODE_IDE;
      else if (strap_s) mode_d = MODE_IO;
      else              mode_d = MODE_MEM;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
      mode_q <= MODE_MEM;
    end else begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
      mode_q <= mode_d;
    end
  end

  assign seq_done = done_q;
  assign mode     = mode_q;
endmodule

// File: rtl/cbf_strobe_decode.sv
// Edge detection and per-mode acceptance of host strobes.
module cbf_strobe_decode
  import card_bus_pkg::*;
#(
  parameter int AW   = 4,
  parameter int NREG = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          oe_s,
  input  logic          iord_s,
  input  logic          iowr_s,
  input  bus_mode_e     mode,
  input  logic          seq_done,
  input  logic          cs_n,
  input  logic          reg_n,
  input  logic [AW-1:0] addr,
  output logic          rd_ev,
  output logic          rd_attr,
  output logic          wr_ev,
  output logic          iord_ev,
  output logic          iord_rise,
  output logic          addr_ok
);
  localparam logic [AW:0] NREG_L = (AW + 1)'(NREG);

  logic oe_p, iord_p, iowr_p;
  logic oe_fall, iord_fall, iowr_rise;
  logic sel, oe_ok, io_ok, oe_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_p   <= 1'b1;
      iord_p <= 1'b1;
      iowr_p <= 1'b1;
    end else begin
      oe_p   <= oe_s;
      iord_p <= iord_s;
      iowr_p <= iowr_s;
    end
  end

  assign oe_fall   = oe_p & ~oe_s;
  assign iord_fall = iord_p & ~iord_s;
  assign iowr_rise = ~iowr_p & iowr_s;
  assign iord_rise = ~iord_p & iord_s;
  assign sel       = seq_done & ~cs_n;
  assign addr_ok   = ({1'b0, addr} < NREG_L);

  always_comb begin
    case (mode)
      MODE_MEM: oe_ok = sel;
      MODE_IO:  oe_ok = sel & ~reg_n;
      default:  oe_ok = 1'b0;
    endcase
  end

  assign io_ok   = sel & ~reg_n & (mode != MODE_MEM);
  assign oe_ev   = oe_fall & oe_ok;
  assign iord_ev = iord_fall & io_ok;
  assign rd_ev   = oe_ev | iord_ev;
  assign rd_attr = oe_ev & ((mode == MODE_IO) | ~reg_n);
  assign wr_ev   = iowr_rise & io_ok & addr_ok;
endmodule

// File: rtl/cbf_regfile.sv
// Common-space data registers, status register, computed attribute bytes,
// and the interrupt pending flag.
module cbf_regfile #(
  parameter int              DW        = 8,
  parameter int              NREG      = 8,
  parameter int              IDX_W     = 3,
  parameter logic [DW-1:0]   ATTR_BASE = 8'hC0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [DW-1:0]    wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic             rd_attr,
  output logic [DW-1:0]    rd_data,
  input  logic             stat_clr,
  input  logic             be_busy,
  input  logic             be_irq,
  output logic             irq_pend
);
  localparam int NDATA = NREG - 1;

  logic [DW-1:0] mem_q [NDATA];
  logic [DW-1:0] common_rd, status_word, attr_rd;
  logic          pend_q, pend_d, irq_q, irq_set;

  for (genvar i = 0; i < NDATA; i++) begin : g_data
    logic          hit;
    logic [DW-1:0] nxt;
    assign hit = wr_en && (wr_idx == IDX_W'(i));
    always_comb nxt = hit ? wr_data : mem_q[i];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mem_q[i] <= '0;
      else        mem_q[i] <= nxt;
    end
  end

  assign status_word = {{(DW-2){1'b0}}, be_busy, pend_q};
  assign attr_rd     = ATTR_BASE | DW'(rd_idx);

  always_comb begin
    common_rd = status_word;
    for (int i = 0; i < NDATA; i++) begin
      if (rd_idx == IDX_W'(i)) common_rd = mem_q[i];
    end
  end

  assign rd_data = rd_attr ? attr_rd : common_rd;

  assign irq_set = be_irq & ~irq_q;

  always_comb begin
    pend_d = pend_q;
    if (stat_clr) pend_d = 1'b0;
    if (irq_set)  pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      irq_q  <= be_irq;
    end
  end

  assign irq_pend = pend_q;
endmodule

// File: rtl/card_bus_front.sv
module card_bus_front
  import card_bus_pkg::*;
#(
  parameter int            DW         = 8,
  parameter int            AW         = 4,
  parameter int            NREG       = 8,
  parameter int            RST_CYCLES = 16,
  parameter logic [DW-1:0] ATTR_BASE  = 8'hC0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_cs_n,
  input  logic          host_reg_n,
  input  logic          host_oe_n,
  input  logic          host_iord_n,
  input  logic          host_iowr_n,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  input  logic          io_strap,
  input  logic          be_busy,
  input  logic          be_irq,
  output logic [DW-1:0] host_rdata,
  output logic          ack_n,
  output logic          ready,
  output logic          irq_out,
  output logic [1:0]    mode_out
);
  localparam int             IDX_W      = $clog2(NREG);
  localparam logic [IDX_W-1:0] STATUS_IDX = IDX_W'(NREG - 1);

  logic [3:0]    sync_s;
  logic          seq_done;
  bus_mode_e     mode;
  logic          rd_ev, rd_attr, wr_ev, iord_ev, iord_rise, addr_ok;
  logic [DW-1:0] rf_rd;
  logic          stat_clr, irq_pend;
  logic [DW-1:0] rdata_q, rdata_d;
  logic          ack_q, ack_d, ready_q, ready_d;
  logic [IDX_W-1:0] idx;

  assign idx = host_addr[IDX_W-1:0];

  cbf_sync #(.W(4), .RST_VAL(4'b0111)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async ({io_strap, host_iowr_n, host_iord_n, host_oe_n}),
    .q_sync  (sync_s)
  );

  cbf_reset_seq #(.RST_CYCLES(RST_CYCLES)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .oe_s     (sync_s[0]),
    .strap_s  (sync_s[3]),
    .seq_done (seq_done),
    .mode     (mode)
  );

  cbf_strobe_decode #(.AW(AW), .NREG(NREG)) u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .oe_s      (sync_s[0]),
    .iord_s    (sync_s[1]),
    .iowr_s    (sync_s[2]),
    .mode      (mode),
    .seq_done  (seq_done),
    .cs_n      (host_cs_n),
    .reg_n     (host_reg_n),
    .addr      (host_addr),
    .rd_ev     (rd_ev),
    .rd_attr   (rd_attr),
    .wr_ev     (wr_ev),
    .iord_ev   (iord_ev),
    .iord_rise (iord_rise),
    .addr_ok   (addr_ok)
  );

  assign stat_clr = rd_ev & addr_ok & ~rd_attr & (idx == STATUS_IDX);

  cbf_regfile #(.DW(DW), .NREG(NREG), .IDX_W(IDX_W), .ATTR_BASE(ATTR_BASE)) u_rf (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_ev),
    .wr_idx   (idx),
    .wr_data  (host_wdata),
    .rd_idx   (idx),
    .rd_attr  (rd_attr),
    .rd_data  (rf_rd),
    .stat_clr (stat_clr),
    .be_busy  (be_busy),
    .be_irq   (be_irq),
    .irq_pend (irq_pend)
  );

  always_comb begin
    rdata_d = rdata_q;
    if (rd_ev) rdata_d = addr_ok ? rf_rd : '0;
    ack_d = ack_q;
    if (iord_rise) ack_d = 1'b0;
    if (iord_ev && addr_ok && (mode == MODE_IO)) ack_d = 1'b1;
    ready_d = seq_done & ~be_busy;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      ack_q   <= 1'b0;
      ready_q <= 1'b0;
    end else begin
      rdata_q <= rdata_d;
      ack_q   <= ack_d;
      ready_q <= ready_d;
    end
  end

  assign host_rdata = rdata_q;
  assign ack_n      = ~ack_q;
  assign ready      = ready_q;
  assign irq_out    = (mode == MODE_IDE) ? irq_pend : ~irq_pend;
  assign mode_out   = mode;
endmodule

// File: rtl/card_bus_front_chk.sv
module card_bus_front_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode_out,
  input logic       ready,
  input logic       ack_n,
  input logic       irq_out,
  input logic       be_irq,
  input logic       be_busy,
  input logic       seq_done,
  input logic       wr_ev
);
  p_ready_low_seq_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !seq_done |-> !ready);

  p_mode_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_done && $past(seq_done)) |-> $stable(mode_out));

  p_ack_io_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_n |-> (mode_out == 2'd1));

  p_ready_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(seq_done) && $past(be_busy)) |-> !ready);

  p_ready_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(seq_done) && !$past(be_busy)) |-> ready);

  p_irq_high_ide_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_done && mode_out == 2'd2 && $rose(be_irq)) |=> irq_out);

  p_irq_low_other_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_done && mode_out != 2'd2 && $rose(be_irq)) |=> !irq_out);

  p_no_wr_seq_r12: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ev |-> (seq_done && mode_out != 2'd0));
endmodule

bind card_bus_front card_bus_front_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mode_out (mode_out),
  .ready    (ready),
  .ack_n    (ack_n),
  .irq_out  (irq_out),
  .be_irq   (be_irq),
  .be_busy  (be_busy),
  .seq_done (seq_done),
  .wr_ev    (wr_ev)
);

// File: tb/card_bus_front_bench.sv
`timescale 1ns/1ps
module card_bus_front_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       host_cs_n, host_reg_n, host_oe_n, host_iord_n, host_iowr_n;
  logic [3:0] host_addr;
  logic [7:0] host_wdata;
  logic       io_strap, be_busy, be_irq;
  logic [7:0] host_rdata;
  logic       ack_n, ready, irq_out;
  logic [1:0] mode_out;

  int n_chk  = 0;
  int n_fail = 0;
  logic finished = 1'b0;

  always #2.5 clk = ~clk;

  card_bus_front u_card_bus_front (
    .clk(clk), .rst_n(rst_n), .host_cs_n(host_cs_n), .host_reg_n(host_reg_n),
    .host_oe_n(host_oe_n), .host_iord_n(host_iord_n), .host_iowr_n(host_iowr_n),
    .host_addr(host_addr), .host_wdata(host_wdata), .io_strap(io_strap),
    .be_busy(be_busy), .be_irq(be_irq), .host_rdata(host_rdata), .ack_n(ack_n),
    .ready(ready), .irq_out(irq_out), .mode_out(mode_out)
  );

  typedef struct packed {
    logic [3:0] a;
    logic [7:0] d;
    logic       rn;
    logic [7:0] e;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{4'd0, 8'h11, 1'b0, 8'h11},
    '{4'd1, 8'h22, 1'b0, 8'h22},
    '{4'd2, 8'h33, 1'b1, 8'h00},
    '{4'd3, 8'h44, 1'b0, 8'h44},
    '{4'd6, 8'h66, 1'b0, 8'h66},
    '{4'd2, 8'h77, 1'b0, 8'h77},
    '{4'd1, 8'h88, 1'b1, 8'h22},
    '{4'd7, 8'h99, 1'b0, 8'h00}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_bus();
    host_cs_n = 1'b1; host_reg_n = 1'b1; host_oe_n = 1'b1;
    host_iord_n = 1'b1; host_iowr_n = 1'b1;
    host_addr = '0; host_wdata = '0; be_busy = 1'b0; be_irq = 1'b0;
  endtask

  task automatic io_write(input logic [3:0] a, input logic [7:0] d1,
                          input logic [7:0] d2, input logic rn);
    @(negedge clk);
    host_addr = a; host_wdata = d1; host_reg_n = rn; host_cs_n = 1'b0;
    repeat (2) @(negedge clk);
    host_iowr_n = 1'b0;
    repeat (3) @(negedge clk);
    host_wdata = d2;
    repeat (2) @(negedge clk);
    host_iowr_n = 1'b1;
    repeat (5) @(negedge clk);
    host_cs_n = 1'b1;
  endtask

  task automatic io_read(input logic [3:0] a, input logic rn,
                         output logic [7:0] d, output logic ak);
    @(negedge clk);
    host_addr = a; host_reg_n = rn; host_cs_n = 1'b0;
    repeat (2) @(negedge clk);
    host_iord_n = 1'b0;
    repeat (5) @(negedge clk);
    d = host_rdata; ak = ack_n;
    host_iord_n = 1'b1;
    repeat (5) @(negedge clk);
    host_cs_n = 1'b1;
  endtask

  task automatic oe_read(input logic [3:0] a, input logic rn, output logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_reg_n = rn; host_cs_n = 1'b0;
    repeat (2) @(negedge clk);
    host_oe_n = 1'b0;
    repeat (5) @(negedge clk);
    d = host_rdata;
    host_oe_n = 1'b1;
    repeat (5) @(negedge clk);
    host_cs_n = 1'b1;
  endtask

  task automatic do_reset(input logic oe_lvl, input logic strap);
    @(negedge clk);
    rst_n = 1'b0;
    idle_bus();
    host_oe_n = oe_lvl; io_strap = strap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (24) @(negedge clk);
    host_oe_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    logic [7:0] d;
    logic       ak;
    rst_n = 1'b0;
    idle_bus();
    io_strap = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset ready", {7'd0, ready}, 8'h00);
    check("R7 reset ack_n", {7'd0, ack_n}, 8'h01);
    check("R9 reset irq_out", {7'd0, irq_out}, 8'h01);
    check("R3 reset rdata", host_rdata, 8'h00);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 ready low in sequence", {7'd0, ready}, 8'h00);
    io_write(4'd0, 8'h5A, 8'h5A, 1'b0);     // R12: issued during the sequence
    repeat (20) @(negedge clk);
    check("R1 ready after sequence", {7'd0, ready}, 8'h01);
    check("R2 io mode", {6'd0, mode_out}, 8'h01);
    io_read(4'd0, 1'b0, d, ak);
    check("R12 write in sequence dropped", d, 8'h00);

    // Table walk in I/O mode: write, then read back (R5, R6, R10 status)
    for (int i = 0; i < 8; i++) begin
      io_write(VECS[i].a, VECS[i].d, VECS[i].d, VECS[i].rn);
      io_read(VECS[i].a, 1'b0, d, ak);
      check("R5 table read-back", d, VECS[i].e);
      check("R7 ack during valid read", {7'd0, ak}, 8'h00);
    end

    io_read(4'd9, 1'b0, d, ak);
    check("R7 invalid addr data", d, 8'h00);
    check("R7 invalid addr ack_n", {7'd0, ak}, 8'h01);

    io_read(4'd3, 1'b0, d, ak);
    io_read(4'd1, 1'b1, d, ak);
    check("R5 reg high read ignored", d, 8'h44);
    check("R5 reg high read no ack", {7'd0, ak}, 8'h01);
    @(negedge clk);
    host_addr = 4'd1; host_reg_n = 1'b0; host_cs_n = 1'b1;
    host_iord_n = 1'b0;
    repeat (5) @(negedge clk);
    check("R5 deselected read ignored", host_rdata, 8'h44);
    host_iord_n = 1'b1;
    repeat (5) @(negedge clk);

    io_write(4'd4, 8'hAA, 8'hBB, 1'b0);
    io_read(4'd4, 1'b0, d, ak);
    check("R6 trailing edge data", d, 8'hBB);

    oe_read(4'd2, 1'b0, d);
    check("R4 io oe attribute", d, 8'hC2);
    oe_read(4'd3, 1'b1, d);
    check("R4 io oe reg high ignored", d, 8'hC2);

    @(negedge clk); be_irq = 1'b1;
    repeat (2) @(negedge clk); be_irq = 1'b0;
    repeat (2) @(negedge clk);
    check("R9 io irq active low", {7'd0, irq_out}, 8'h00);
    repeat (10) @(negedge clk);
    check("R10 irq held", {7'd0, irq_out}, 8'h00);
    io_read(4'd7, 1'b0, d, ak);
    check("R10 status pending", d, 8'h01);
    check("R10 irq cleared", {7'd0, irq_out}, 8'h01);
    @(negedge clk); be_busy = 1'b1;
    repeat (2) @(negedge clk);
    check("R8 ready low when busy", {7'd0, ready}, 8'h00);
    io_read(4'd7, 1'b0, d, ak);
    check("R10 status busy bit", d, 8'h02);
    be_busy = 1'b0;
    repeat (2) @(negedge clk);
    check("R8 ready back", {7'd0, ready}, 8'h01);

    // Memory mode
    do_reset(1'b1, 1'b0);
    check("R2 memory mode", {6'd0, mode_out}, 8'h00);
    io_write(4'd1, 8'h77, 8'h77, 1'b0);
    oe_read(4'd1, 1'b1, d);
    check("R11 memory iowr ignored / R3 common", d, 8'h00);
    oe_read(4'd5, 1'b0, d);
    check("R3 memory attribute", d, 8'hC5);
    io_read(4'd2, 1'b0, d, ak);
    check("R11 memory iord ignored", d, 8'hC5);
    check("R7 no ack memory", {7'd0, ak}, 8'h01);
    @(negedge clk); be_irq = 1'b1;
    repeat (2) @(negedge clk); be_irq = 1'b0;
    check("R9 memory irq active low", {7'd0, irq_out}, 8'h00);

    // Disk-compatible mode
    do_reset(1'b0, 1'b0);
    check("R2 ide mode", {6'd0, mode_out}, 8'h02);
    io_write(4'd3, 8'h3C, 8'h3C, 1'b0);
    io_read(4'd3, 1'b0, d, ak);
    check("R11 ide io read-back", d, 8'h3C);
    check("R7 no ack ide", {7'd0, ak}, 8'h01);
    oe_read(4'd2, 1'b0, d);
    check("R4 ide oe ignored", d, 8'h3C);
    check("R9 ide irq idle low", {7'd0, irq_out}, 8'h00);
    @(negedge clk); be_irq = 1'b1;
    repeat (2) @(negedge clk); be_irq = 1'b0;
    check("R9 ide irq active high", {7'd0, irq_out}, 8'h01);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(negedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule